// File: doc/BRIEF.md
# Transfer Length and Completion Sequencer

This block runs one information-transfer phase of a SCSI host controller. A start request chooses the length of the burst. The length is the smaller of the 16-bit transfer counter and a cap. In command phase the cap is a fixed number of bytes. In a data phase the cap is the magnitude of the signed byte count still owed by the phase. The block then moves that many bytes over a plain request/acknowledge DMA handshake. It counts the transfer counter down as each byte moves. At the end it writes the completion values into the status, interrupt, sequence-step and flags registers and raises the interrupt line.

A second request runs the status-phase response. This sends two bytes toward the host: first the sense/status value, then a zero byte. It then writes a different completion pattern. A done indication from the data source ends a running transfer early. The same indication has no effect when nothing is running. An interrupt acknowledge clears the interrupt line and the interrupt flag in the status register. Register decoding, memory addressing and the target model live outside this block.

Top module: `xfer_len_seq`

## Requirements
- R1: After reset, the status, interrupt, sequence and flags registers and the counter read zero, and `irq` and `dma_req` are low.
- R2: A pulse on `cnt_wr` while idle loads the counter from `{cnt_mid_in, cnt_lo_in}`. The new value is visible on `cnt_mid`/`cnt_lo` one cycle later.
- R3: In command phase, a transfer moves min(count, CMD_CAP) bytes, where count = `cnt_mid` shifted left by 8, OR `cnt_lo`. It drives `dma_to_dev` high, and the status bits [2:0] read 2.
- R4: In a data phase, a transfer moves min(count, |remain|) bytes. A negative `remain` means toward the device: `dma_to_dev` is 1 and status bits [2:0] read 0. Otherwise `dma_to_dev` is 0 and status bits [2:0] read 1.
- R5: Accepting `start` clears status bit 4 (terminal count) and writes the phase code into status bits [2:0].
- R6: The counter drops by one for each acknowledged byte and never goes below zero.
- R7: The cycle after the final acknowledge, completion sets status bits 7 (interrupt) and 4 and keeps the phase bits. It sets interrupt to 0x10 (bus service), zeroes the sequence step, flags and both counter bytes, and raises `irq`.
- R8: A `src_done` pulse during a transfer ends it on that edge with the R7 pattern.
- R9: A `src_done` pulse while idle changes no register and does not raise `irq`.
- R10: A transfer of length zero asserts no `dma_req` and completes one cycle after it starts.
- R11: `stat_go` sends `sense` and then 0x00 toward the host (`dma_to_dev` = 0). After the second acknowledge, status reads 0x93, interrupt reads 0x18, sequence reads 4 and flags read 2, and `irq` rises.
- R12: `intr_ack` lowers `irq` and clears only status bit 7.
- R13: `start`, `stat_go` and `cnt_wr` have no effect while a transfer or status response is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wr | input | 1 | Load transfer counter |
| cnt_lo_in | input | 8 | Counter low byte to load |
| cnt_mid_in | input | 8 | Counter middle byte to load |
| cmd_phase | input | 1 | Current phase is command phase |
| remain | input | REM_W | Signed bytes left in the phase (negative: toward device) |
| start | input | 1 | Begin an information transfer |
| stat_go | input | 1 | Begin the status-phase response |
| sense | input | 8 | Status value sent first in the response |
| src_done | input | 1 | Data source finished early |
| dma_ack | input | 1 | One byte accepted |
| intr_ack | input | 1 | Interrupt acknowledge |
| dma_req | output | 1 | Byte transfer requested |
| dma_to_dev | output | 1 | Direction, 1 = toward device |
| dma_wdata | output | 8 | Status-response byte |
| cnt_lo | output | 8 | Counter low byte |
| cnt_mid | output | 8 | Counter middle byte |
| stat_reg | output | 8 | Status register |
| intr_reg | output | 8 | Interrupt register |
| seq_reg | output | 8 | Sequence-step register |
| flags_reg | output | 8 | Flags register |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults: REM_W = 24 and CMD_CAP = 32. With a 24-bit signed remainder, the bench can set data phases whose remainder is larger than the counter, smaller than it, and above 255. This tests the carry into the counter's middle byte. A cap of 32 lets a command-phase vector with a counter of 100 show the cap taking effect within a short burst. Zero-length, early-done and idle-done cases cover the completion corners.

// File: rtl/xfer_seq_pkg.sv
// Shared constants and types for the transfer sequencer.
// Assumes 8-bit register images; bit positions are fixed by the requirements.
package xfer_seq_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_STAT} seq_state_e;

    localparam int ST_IN_BIT  = 7;
    localparam int ST_TC_BIT  = 4;

    localparam logic [2:0] PH_DOUT = 3'd0;
    localparam logic [2:0] PH_DIN  = 3'd1;
    localparam logic [2:0] PH_CMD  = 3'd2;
    localparam logic [2:0] PH_STAT = 3'd3;

    localparam logic [7:0] IR_BUS  = 8'h10;
    localparam logic [7:0] IR_FC   = 8'h08;

    localparam logic [7:0] SEQ_CMD_DONE = 8'h04;
    localparam logic [7:0] FLG_STAT_DONE = 8'h02;
endpackage

// File: rtl/xfer_len_calc.sv
// Length selector: picks the burst length from the counter and the phase.
// Assumes remain is two's complement; the command phase ignores remain.
module xfer_len_calc #(
    parameter int CNT_W   = 16,
    parameter int REM_W   = 24,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [REM_W-1:0] remain,
    input  logic             cmd_phase,
    output logic [CNT_W-1:0] len,
    output logic             to_dev,
    output logic [2:0]       phase
);
    import xfer_seq_pkg::*;

    localparam int CMP_W = (REM_W > CNT_W) ? REM_W : CNT_W;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CMD_CAP);

    logic             neg;
    logic [REM_W-1:0] mag;
    logic [CMP_W-1:0] cnt_x, mag_x;

    // Magnitude of the signed remainder, widened for comparison.
    always_comb begin
        neg   = remain[REM_W-1];
        mag   = neg ? (~remain + 1'b1) : remain;
        cnt_x = CMP_W'(count);
        mag_x = CMP_W'(mag);
    end

    // Length, direction and phase code for the chosen phase.
    always_comb begin
        if (cmd_phase) begin
            len    = (count < CAP_V) ? count : CAP_V;
            to_dev = 1'b1;
            phase  = PH_CMD;
        end else begin
            len    = (cnt_x < mag_x) ? count : CNT_W'(mag_x);
            to_dev = neg;
            phase  = neg ? PH_DOUT : PH_DIN;
        end
    end
endmodule

// File: rtl/xfer_count_reg.sv
// Transfer counter: loadable, saturating down-counter with a clear.
// Assumes load is only requested while the sequencer is idle.
module xfer_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    // Counter update: clear beats load beats decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec && count != '0)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/xfer_status_regs.sv
// Status-side registers: status, interrupt, sequence step, flags and irq.
// Assumes at most one of data_done/stat_done per cycle.
module xfer_status_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic [2:0] phase_in,
    input  logic       data_done,
    input  logic       stat_done,
    input  logic       intr_ack,
    output logic [7:0] stat_reg,
    output logic [7:0] intr_reg,
    output logic [7:0] seq_reg,
    output logic [7:0] flags_reg,
    output logic       irq
);
    import xfer_seq_pkg::*;

    // Register writes by event; completions win over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_reg  <= '0;
            intr_reg  <= '0;
            seq_reg   <= '0;
            flags_reg <= '0;
            irq       <= 1'b0;
        end else if (data_done) begin
            stat_reg[ST_IN_BIT] <= 1'b1;
            stat_reg[ST_TC_BIT] <= 1'b1;
            intr_reg  <= IR_BUS;
            seq_reg   <= '0;
            flags_reg <= '0;
            irq       <= 1'b1;
        end else if (stat_done) begin
            stat_reg  <= 8'h90 | {5'd0, PH_STAT};
            intr_reg  <= IR_BUS | IR_FC;
            seq_reg   <= SEQ_CMD_DONE;
            flags_reg <= FLG_STAT_DONE;
            irq       <= 1'b1;
        end else if (start_evt) begin
            stat_reg[ST_TC_BIT] <= 1'b0;
            stat_reg[2:0]       <= phase_in;
        end else if (intr_ack) begin
            stat_reg[ST_IN_BIT] <= 1'b0;
            irq                 <= 1'b0;
        end
    end
endmodule

// File: rtl/xfer_len_seq.sv
// Transfer length and completion sequencer top.
// Runs one data/command burst or a two-byte status response over a
// request/acknowledge handshake and posts the completion registers.
// Assumes dma_ack is only asserted while dma_req is high.
module xfer_len_seq #(
    parameter int REM_W   = 24,
    parameter int CMD_CAP = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [7:0]       cnt_lo_in,
    input  logic [7:0]       cnt_mid_in,
    input  logic             cmd_phase,
    input  logic [REM_W-1:0] remain,
    input  logic             start,
    input  logic             stat_go,
    input  logic [7:0]       sense,
    input  logic             src_done,
    input  logic             dma_ack,
    input  logic             intr_ack,
    output logic             dma_req,
    output logic             dma_to_dev,
    output logic [7:0]       dma_wdata,
    output logic [7:0]       cnt_lo,
    output logic [7:0]       cnt_mid,
    output logic [7:0]       stat_reg,
    output logic [7:0]       intr_reg,
    output logic [7:0]       seq_reg,
    output logic [7:0]       flags_reg,
    output logic             irq
);
    import xfer_seq_pkg::*;

    localparam int CNT_W = 16;

    seq_state_e       state_q;
    logic [CNT_W-1:0] left_q, count, len;
    logic             dir_q, to_dev, byte_q, busy_w;
    logic [7:0]       sense_q;
    logic [2:0]       phase;
    logic             go_x, go_s, data_done, stat_done, dec;

    xfer_len_calc #(.CNT_W(CNT_W), .REM_W(REM_W), .CMD_CAP(CMD_CAP)) u_len (
        .count(count), .remain(remain), .cmd_phase(cmd_phase),
        .len(len), .to_dev(to_dev), .phase(phase)
    );

    xfer_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_wr && !busy_w),
        .load_val({cnt_mid_in, cnt_lo_in}), .dec(dec), .clear(data_done),
        .count(count)
    );

    xfer_status_regs u_regs (
        .clk(clk), .rst_n(rst_n), .start_evt(go_x), .phase_in(phase),
        .data_done(data_done), .stat_done(stat_done), .intr_ack(intr_ack),
        .stat_reg(stat_reg), .intr_reg(intr_reg), .seq_reg(seq_reg),
        .flags_reg(flags_reg), .irq(irq)
    );

    // Event decode from the current state and the request inputs.
    always_comb begin
        busy_w    = (state_q != ST_IDLE);
        go_x      = !busy_w && start;
        go_s      = !busy_w && stat_go && !start;
        dec       = (state_q == ST_XFER) && dma_ack && (left_q != '0);
        data_done = (state_q == ST_XFER) &&
                    ((left_q == '0) || src_done || (dec && left_q == 1));
        stat_done = (state_q == ST_STAT) && dma_ack && byte_q;
    end

    // Sequencer state, bytes left, direction and response byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            dir_q   <= 1'b0;
            byte_q  <= 1'b0;
            sense_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go_x) begin
                        state_q <= ST_XFER;
                        left_q  <= len;
                        dir_q   <= to_dev;
                    end else if (go_s) begin
                        state_q <= ST_STAT;
                        byte_q  <= 1'b0;
                        sense_q <= sense;
                    end
                end
                ST_XFER: begin
                    if (data_done) begin
                        state_q <= ST_IDLE;
                        left_q  <= '0;
                    end else if (dec) begin
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_STAT: begin
                    if (stat_done)
                        state_q <= ST_IDLE;
                    else if (dma_ack)
                        byte_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake and register-image outputs.
    always_comb begin
        dma_req    = ((state_q == ST_XFER) && (left_q != '0)) || (state_q == ST_STAT);
        dma_to_dev = (state_q == ST_XFER) && dir_q;
        dma_wdata  = ((state_q == ST_STAT) && !byte_q) ? sense_q : 8'h00;
        cnt_lo     = count[7:0];
        cnt_mid    = count[15:8];
    end
endmodule

// File: rtl/xfer_len_seq_chk.sv
// Property checker for the transfer sequencer, attached by bind.
// Assumes busy is high whenever a burst or status response is running.
module xfer_len_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       start,
    input logic       stat_go,
    input logic       cnt_wr,
    input logic       dma_req,
    input logic       irq,
    input logic [7:0] stat_reg,
    input logic [7:0] intr_reg,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_mid
);
    a_r5_start_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> !stat_reg[4]);

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        ({cnt_mid, cnt_lo} == 16'd0 && !cnt_wr) |=> ({cnt_mid, cnt_lo} == 16'd0));

    a_r7_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat_reg[7] && stat_reg[4] && intr_reg[4]));

    a_r9_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !stat_go) |=> !$rose(irq));

    a_r13_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> busy);
endmodule

bind xfer_len_seq xfer_len_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .start(start), .stat_go(stat_go),
    .cnt_wr(cnt_wr), .dma_req(dma_req), .irq(irq), .stat_reg(stat_reg),
    .intr_reg(intr_reg), .cnt_lo(cnt_lo), .cnt_mid(cnt_mid)
);

// File: tb/xfer_len_seq_tb.sv
`timescale 1ns/1ps
module xfer_len_seq_tb;
    typedef struct packed {
        logic        cmd;
        logic [23:0] rem;
        logic [15:0] cnt;
        logic [15:0] len;
        logic        dir;
        logic [2:0]  ph;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 24'd0,      16'd100, 16'd32,  1'b1, 3'd2},
        '{1'b1, 24'd0,      16'd5,   16'd5,   1'b1, 3'd2},
        '{1'b0, 24'd7,      16'd40,  16'd7,   1'b0, 3'd1},
        '{1'b0, 24'hFFFFCE, 16'd3,   16'd3,   1'b1, 3'd0},
        '{1'b0, 24'hFFFEFC, 16'd300, 16'd260, 1'b1, 3'd0},
        '{1'b0, 24'd600,    16'd528, 16'd528, 1'b0, 3'd1},
        '{1'b0, 24'd0,      16'd9,   16'd0,   1'b0, 3'd1}
    };

    logic clk = 0, rst_n = 0;
    logic cnt_wr = 0, cmd_phase = 0, start = 0, stat_go = 0;
    logic src_done = 0, dma_ack = 0, intr_ack = 0;
    logic [7:0] cnt_lo_in = 0, cnt_mid_in = 0, sense = 0;
    logic [23:0] remain = 0;
    logic dma_req, dma_to_dev, irq;
    logic [7:0] dma_wdata, cnt_lo, cnt_mid, stat_reg, intr_reg, seq_reg, flags_reg;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    xfer_len_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_lo_in(cnt_lo_in),
        .cnt_mid_in(cnt_mid_in), .cmd_phase(cmd_phase), .remain(remain),
        .start(start), .stat_go(stat_go), .sense(sense), .src_done(src_done),
        .dma_ack(dma_ack), .intr_ack(intr_ack), .dma_req(dma_req),
        .dma_to_dev(dma_to_dev), .dma_wdata(dma_wdata), .cnt_lo(cnt_lo),
        .cnt_mid(cnt_mid), .stat_reg(stat_reg), .intr_reg(intr_reg),
        .seq_reg(seq_reg), .flags_reg(flags_reg), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cnt_lo_in = v[7:0]; cnt_mid_in = v[15:8]; cnt_wr = 1;
        @(negedge clk); cnt_wr = 0;
    endtask

    task automatic pulse_start(input logic cmd, input logic [23:0] rem);
        cmd_phase = cmd; remain = rem; start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic ack_all(output int n);
        n = 0;
        while (dma_req && n < 1000) begin
            dma_ack = 1; @(negedge clk); n++;
        end
        dma_ack = 0;
    endtask

    task automatic clear_irq;
        intr_ack = 1; @(negedge clk); intr_ack = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 stat", stat_reg, 0);
        check("R1 intr/seq/flags", {intr_reg, seq_reg, flags_reg}, 0);
        check("R1 irq/req", {irq, dma_req}, 0);
        check("R1 count", {cnt_mid, cnt_lo}, 0);

        // Table walk: R2 load, R3/R4 length, R5 start, R7/R10 completion, R12 ack
        for (int i = 0; i < NV; i++) begin
            load_cnt(VECS[i].cnt);
            check("R2 counter load", {cnt_mid, cnt_lo}, VECS[i].cnt);
            pulse_start(VECS[i].cmd, VECS[i].rem);
            check("R5 phase and tc", {stat_reg[4], stat_reg[2:0]}, {1'b0, VECS[i].ph});
            if (VECS[i].len != 0)
                check("R4 direction", dma_to_dev, VECS[i].dir);
            else
                check("R10 no request", dma_req, 0);
            ack_all(n);
            @(negedge clk);
            check(VECS[i].cmd ? "R3 length" : (VECS[i].len == 0 ? "R10 length" : "R4 length"),
                  n, VECS[i].len);
            check("R7 status", stat_reg, 8'h90 | VECS[i].ph);
            check("R7 intr/seq/flags", {intr_reg, seq_reg, flags_reg}, 24'h100000);
            check("R7 counter cleared, irq", {cnt_mid, cnt_lo, 7'd0, irq}, 24'h000001);
            clear_irq();
            check("R12 ack", {irq, stat_reg}, {1'b0, 8'h10 | VECS[i].ph});
        end

        // R6 decrement, then R8 early done
        load_cnt(16'd10);
        pulse_start(1'b0, 24'd100);
        dma_ack = 1; repeat (3) @(negedge clk); dma_ack = 0;
        check("R6 decrement", {cnt_mid, cnt_lo}, 16'd7);
        check("R6 still requesting", dma_req, 1);
        src_done = 1; @(negedge clk); src_done = 0;
        check("R8 early done", {irq, dma_req, intr_reg}, {1'b1, 1'b0, 8'h10});
        check("R8 counter cleared", {cnt_mid, cnt_lo}, 0);
        clear_irq();

        // R9 done pulse while idle
        src_done = 1; @(negedge clk); src_done = 0; @(negedge clk);
        check("R9 idle done", {irq, stat_reg, intr_reg}, {1'b0, 8'h11, 8'h10});

        // R13 start and load ignored while busy
        load_cnt(16'd4);
        pulse_start(1'b0, 24'd4);
        dma_ack = 1; @(negedge clk); dma_ack = 0;
        cnt_lo_in = 8'd200; cnt_wr = 1;
        pulse_start(1'b1, 24'd0);
        cnt_wr = 0;
        check("R13 busy start", stat_reg[2:0], 3'd1);
        check("R13 busy load", {cnt_mid, cnt_lo}, 16'd3);
        ack_all(n);
        check("R13 remaining bytes", n, 3);
        clear_irq();

        // R11 status response
        sense = 8'hA5; stat_go = 1; @(negedge clk); stat_go = 0;
        check("R11 first byte", {dma_req, dma_to_dev, dma_wdata}, {2'b10, 8'hA5});
        dma_ack = 1; @(negedge clk);
        check("R11 second byte", {dma_req, dma_wdata}, {1'b1, 8'h00});
        @(negedge clk); dma_ack = 0;
        check("R11 status/intr", {stat_reg, intr_reg}, 16'h9318);
        check("R11 seq/flags/irq", {seq_reg, flags_reg, 7'd0, irq}, 24'h040201);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule